// File: doc/BRIEF.md
# Register-Commanded PHY Management Master

This block runs clause-22 PHY management cycles on an MDC/MDIO pair. Software writes one 32-bit command word. The word packs the data, the PHY address, the register address and a read/write select. If the master is idle, the write starts a frame at once. While the frame shifts out, the same word reads back with a busy bit set. When the frame ends, busy drops. For a read, the sixteen bits returned by the PHY replace the data field and a read-valid bit is set.

Each frame is built from the accepted command. It has an all-ones preamble, start `01`, an opcode, the two 5-bit addresses, a turnaround and sixteen data bits, all sent most significant bit first. MDC is the system clock divided by a parameter. MDIO changes only while MDC is low, and read data is taken at the rising edge of MDC. Each completed command gives a one-cycle done pulse. The surrounding port logic uses this pulse to set bit 29 of its interrupt cause register.

Top module: `mdio_cmd_master`

## Requirements
- R1: A register write while busy (bit 28) is 0 is accepted. From the next cycle, bits 26:0 read back the written value: data in 15:0, PHY address in 20:16, register address in 25:21, and bit 26 = 1 for read or 0 for write.
- R2: A write command sends, MSB first, PRE_BITS ones, then `01`, `01`, the PHY address, the register address, `10` and the 16 data bits. MDIO output enable stays high for every bit.
- R3: A read command sends the preamble, `01`, `10`, the PHY address and the register address. Output enable then goes low from the first turnaround bit to the end of the frame, covering two turnaround bit times plus the 16 data bits. MDIO output reads 0 while the enable is low.
- R4: One bit time is CLK_DIV system clocks. MDC is low for the first half and high for the second. A frame has exactly PRE_BITS+32 rising MDC edges. MDIO output changes only while MDC is low.
- R5: On a read, MDIO input is sampled at each rising MDC edge in the data phase. The 16 samples, MSB first, replace bits 15:0 at the end, and read valid (bit 27) becomes 1.
- R6: Busy (bit 28) is 1 from the cycle after an accepted write for (PRE_BITS+32)*CLK_DIV cycles, then returns to 0.
- R7: A write while busy is 1 is ignored: the readback fields and the frame in progress are unchanged.
- R8: An accepted write clears read valid. A completed write command leaves read valid at 0.
- R9: `smi_done` is high for exactly one cycle, in the cycle in which busy first reads 0 after a command.
- R10: After reset and while idle, MDC is low and MDIO output enable is low. Bits 31:29 of the readback always read 0, and the whole word reads 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Command word to write |
| reg_rdata | output | 32 | Command/status word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| smi_done | output | 1 | One-cycle command-done pulse for cause bit 29 |

## Verification
The bench builds the master with CLK_DIV = 4 and the full 32-bit preamble. A frame then takes 256 clocks, so every PHY address from 0 to 31 can be run both as a write and as a read, each with a register address and data word derived arithmetically, inside a short run. The bench models the PHY itself. It records every bit and enable value on rising MDC and returns a computed word in the data phase. This lets it compare whole frames, exact busy length, read capture and the done pulse against arithmetic expectations. A write injected mid-frame exercises the busy-ignore rule.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

   localparam int CMD_BITS    = 27;
   localparam int RVALID_BIT  = 27;
   localparam int BUSY_BIT    = 28;
   localparam int BODY_BITS   = 32;
   localparam int TA_OFFSET   = 14;   // first turnaround bit after the preamble

   // Packed so that it maps directly onto command bits 26:0.
   typedef struct packed {
      logic       rd;
      logic [4:0] regad;
      logic [4:0] phy;
      logic [15:0] data;
   } mdio_cmd_t;

   // Frame body after the preamble, MSB first on the wire.
   function automatic logic [BODY_BITS-1:0] frame_body(input mdio_cmd_t c);
      if (c.rd)
         return {2'b01, 2'b10, c.phy, c.regad, 18'b0};
      else
         return {2'b01, 2'b01, c.phy, c.regad, 2'b10, c.data};
   endfunction

endpackage

// File: rtl/mdc_phase_gen.sv
module mdc_phase_gen #(
   parameter int CLK_DIV = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_evt,
   output logic end_evt
);
   localparam int DIV_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int HALF  = CLK_DIV / 2;

   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || end_evt)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign mdc      = run && (cnt_q >= DIV_W'(HALF));
   assign rise_evt = run && (cnt_q == DIV_W'(HALF - 1));
   assign end_evt  = run && (cnt_q == DIV_W'(CLK_DIV - 1));

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
   import mdio_cmd_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  mdio_cmd_t   cmd,
   input  logic        rise_evt,
   input  logic        end_evt,
   input  logic        mdio_i,
   output logic        active,
   output logic        mdio_o,
   output logic        mdio_oe,
   output logic        done_evt,
   output logic [15:0] rd_data
);
   localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam int REL_IDX    = PRE_BITS + TA_OFFSET;

   logic                  active_q, is_rd_q;
   logic [FRAME_BITS-1:0] sh_q;
   logic [IDX_W-1:0]      idx_q;
   logic [15:0]           rx_q;
   logic                  last_bit;

   assign last_bit = (idx_q == IDX_W'(FRAME_BITS - 1));
   assign done_evt = active_q && end_evt && last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         is_rd_q  <= 1'b0;
         sh_q     <= '0;
         idx_q    <= '0;
         rx_q     <= '0;
      end else if (start) begin
         active_q <= 1'b1;
         is_rd_q  <= cmd.rd;
         sh_q     <= {{PRE_BITS{1'b1}}, frame_body(cmd)};
         idx_q    <= '0;
      end else if (active_q) begin
         if (rise_evt)
            rx_q <= {rx_q[14:0], mdio_i};
         if (end_evt) begin
            sh_q <= sh_q << 1;
            if (last_bit)
               active_q <= 1'b0;
            else
               idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign active  = active_q;
   assign mdio_oe = active_q && !(is_rd_q && (idx_q >= IDX_W'(REL_IDX)));
   assign mdio_o  = mdio_oe && sh_q[FRAME_BITS-1];
   assign rd_data = rx_q;

endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master
   import mdio_cmd_pkg::*;
#(
   parameter int CLK_DIV  = 64,
   parameter int PRE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i,
   output logic        smi_done
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (PRE_BITS < 1 || PRE_BITS > 64) begin : g_bad_pre
         $error("PRE_BITS must lie in 1..64");
      end
   endgenerate

   mdio_cmd_t   cmd_q;
   logic        busy_q, rvalid_q, done_q;
   logic        accept, eng_active, rise_evt, end_evt, done_evt;
   logic [15:0] rd_data;
   mdio_cmd_t   new_cmd;

   assign new_cmd = mdio_cmd_t'(reg_wdata[CMD_BITS-1:0]);
   assign accept  = reg_wr && !busy_q;

   mdc_phase_gen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (eng_active),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .end_evt  (end_evt)
   );

   mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .cmd      (new_cmd),
      .rise_evt (rise_evt),
      .end_evt  (end_evt),
      .mdio_i   (mdio_i),
      .active   (eng_active),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .done_evt (done_evt),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= '0;
         busy_q   <= 1'b0;
         rvalid_q <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= done_evt;
         if (accept) begin
            cmd_q    <= new_cmd;
            busy_q   <= 1'b1;
            rvalid_q <= 1'b0;
         end else if (done_evt) begin
            busy_q <= 1'b0;
            if (cmd_q.rd) begin
               cmd_q.data <= rd_data;
               rvalid_q   <= 1'b1;
            end
         end
      end
   end

   assign reg_rdata = {3'b000, busy_q, rvalid_q, cmd_q};
   assign smi_done  = done_q;

endmodule

// File: rtl/mdio_cmd_master_chk.sv
module mdio_cmd_master_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr,
   input logic [31:0] reg_rdata,
   input logic        mdc,
   input logic        mdio_o,
   input logic        mdio_oe,
   input logic        smi_done
);
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[28] |-> (!mdc && !mdio_oe)); // R10

   AST_TOP_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[31:29] == 3'b000); // R10

   AST_MDIO_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mdio_o) |-> !mdc); // R4

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rdata[28]) |=> (reg_rdata[28] && !reg_rdata[27])); // R6

   AST_ACCEPT_CLR_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rdata[28]) |=> !reg_rdata[27]); // R8

   AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_rdata[28]) |=> ($stable(reg_rdata[26:0]) || smi_done)); // R7

   AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      smi_done |-> (!reg_rdata[28] && $past(reg_rdata[28]))); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      smi_done |=> !smi_done); // R9

endmodule

bind mdio_cmd_master mdio_cmd_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_rdata (reg_rdata),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe),
   .smi_done  (smi_done)
);

// File: tb/tb_mdio_cmd_master.sv
module tb_mdio_cmd_master;
   localparam int CLK_PERIOD = 10;
   localparam int DIV        = 4;
   localparam int PRE        = 32;
   localparam int FBITS      = PRE + 32;
   localparam int FCYC       = FBITS * DIV;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe, mdio_i, smi_done;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   int          bc = 0;
   int          base = 0;
   int          hi_cnt = 0;
   logic [63:0] cap = '0, oecap = '0;
   logic [15:0] rd_word = '0;
   int          rel;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_cmd_master #(.CLK_DIV(DIV), .PRE_BITS(PRE)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i), .smi_done(smi_done)
   );

   // PHY model: record wire on rising MDC, drive read data in the data phase.
   always @(posedge mdc) begin
      bc    <= bc + 1;
      cap   <= {cap[62:0], mdio_o};
      oecap <= {oecap[62:0], mdio_oe};
   end
   always @(posedge clk) if (mdc) hi_cnt <= hi_cnt + 1;

   assign rel    = bc - base;
   assign mdio_i = (rel >= 48 && rel < 64) ? rd_word[63 - rel] : 1'b1;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input bit rd, input logic [4:0] phy, input logic [4:0] ra,
                          input logic [15:0] data, input logic [15:0] phy_word,
                          input bit inject);
      int cyc;
      int hi0;
      logic [63:0] exp_f, exp_oe;
      logic [31:0] exp_rb, word;
      word = {5'b0, rd, ra, phy, data};
      base = bc; hi0 = hi_cnt; rd_word = phy_word;
      @(negedge clk) begin reg_wr = 1'b1; reg_wdata = word; end
      @(negedge clk) reg_wr = 1'b0;
      chk(reg_rdata[28] == 1'b1, "R6 busy after accept", 64'(reg_rdata), 64'(32'h1000_0000));
      chk(reg_rdata[27] == 1'b0, "R8 rvalid cleared by new command", 64'(reg_rdata[27]), 64'd0);
      chk(reg_rdata[26:0] == word[26:0], "R1 command readback", 64'(reg_rdata[26:0]), 64'(word[26:0]));
      cyc = 0;
      while (!smi_done && cyc < FCYC + 20) begin
         @(negedge clk);
         cyc++;
         if (inject && cyc == 100) begin
            reg_wr = 1'b1; reg_wdata = ~word & 32'h07FF_FFFF;
         end else begin
            reg_wr = 1'b0;
            if (inject && cyc == 102)
               chk(reg_rdata[26:0] == word[26:0], "R7 write while busy ignored",
                   64'(reg_rdata[26:0]), 64'(word[26:0]));
         end
      end
      chk(cyc == FCYC, "R6 R9 busy length and done timing", 64'(cyc), 64'(FCYC));
      chk(reg_rdata[28] == 1'b0, "R9 busy low with done", 64'(reg_rdata[28]), 64'd0);
      chk(bc - base == FBITS, "R4 rising MDC count", 64'(bc - base), 64'(FBITS));
      chk(hi_cnt - hi0 == FCYC/2, "R4 MDC high half", 64'(hi_cnt - hi0), 64'(FCYC/2));
      exp_f  = rd ? {32'hFFFF_FFFF, 2'b01, 2'b10, phy, ra, 18'b0}
                  : {32'hFFFF_FFFF, 2'b01, 2'b01, phy, ra, 2'b10, data};
      exp_oe = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
      chk(cap == exp_f, rd ? "R3 read frame bits" : "R2 write frame bits", cap, exp_f);
      chk(oecap == exp_oe, rd ? "R3 read turnaround release" : "R2 write enable", oecap, exp_oe);
      exp_rb = rd ? {3'b0, 1'b0, 1'b1, 1'b1, ra, phy, phy_word}
                  : {3'b0, 1'b0, 1'b0, 1'b0, ra, phy, data};
      chk(reg_rdata == exp_rb, rd ? "R5 read data and rvalid" : "R8 write leaves rvalid 0",
          64'(reg_rdata), 64'(exp_rb));
      @(negedge clk);
      chk(smi_done == 1'b0, "R9 done single cycle", 64'(smi_done), 64'd0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0, "R10 idle lines", {62'b0, mdc, mdio_oe}, 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(reg_rdata == 32'h0, "R10 reset readback", 64'(reg_rdata), 64'd0);
      chk(mdc == 1'b0 && mdio_oe == 1'b0 && smi_done == 1'b0, "R10 reset lines",
          {61'b0, mdc, mdio_oe, smi_done}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      for (int i = 0; i < 32; i++) begin
         run_cmd(1'b0, 5'(i), 5'((i * 7) % 32), 16'(i * 16'h0421) ^ 16'hA5C3, 16'h0, 1'b0);
         run_cmd(1'b1, 5'(31 - i), 5'(i), 16'hFFFF, 16'(16'h1234 + i * 16'h0F0F), 1'b0);
      end
      run_cmd(1'b1, 5'd9, 5'd17, 16'h0, 16'h8001, 1'b1);
      run_cmd(1'b0, 5'd22, 5'd3, 16'h5AA5, 16'h0, 1'b1);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule